// File: doc/BRIEF.md
# Modulo Timer Counter with Byte-Wide Register Access

This block is a 16-bit up-counter that advances on a timer-clock enable tick and wraps back to zero after it has matched a programmable limit. Software reaches it over an 8-bit register port, so each 16-bit quantity is split into an upper and a lower byte. Reading the upper count byte captures the lower count byte in a holding buffer, so that two byte reads give a coherent 16-bit value even while the counter keeps running.

The limit register is loaded as a byte pair. Writing the upper byte stages it and suppresses overflow flagging. Writing the lower byte commits both halves at once and resumes flagging. A control/status register holds the overflow flag, the interrupt enable and a self-clearing counter-reset bit. The overflow flag is cleared by a read-then-write handshake, and an interrupt request follows the flag when the enable bit is set.

Top module: `modtimer`

## Requirements
- R1: After synchronous reset the count reads 0x0000, the limit reads 0xFFFF, and the control/status register at offset 0x20 reads 0x00.
- R2: The count increments only on clock edges where `tick` is high. On the tick where the count equals the limit, the count returns to 0x0000.
- R3: The overflow flag (bit 7 of offset 0x20) sets on the tick where the count wraps from the limit to zero.
- R4: A read of the upper count byte (offset 0x21) copies the lower count byte into a buffer. The next read of the lower count byte (offset 0x22) returns that buffered value and not the live count.
- R5: Repeated upper-byte reads leave the buffered value unchanged. Only a lower-byte read releases the buffer. A lower-byte read with no buffer held returns the live lower byte.
- R6: Writing the limit upper byte (offset 0x23) blocks the overflow flag until the limit lower byte (offset 0x24) is written. That write commits the new 16-bit limit, and both limit bytes read back the written values.
- R7: Writing 1 to bit 5 of offset 0x20 clears the count to 0x0000. The bit reads back as 0, and the overflow flag does not change.
- R8: The overflow flag clears when offset 0x20 is read while the flag is set and is then written with bit 7 at 0. A new overflow in the same cycle as that write leaves the flag set.
- R9: `irq` is high exactly when the overflow flag and the interrupt enable (bit 6 of offset 0x20) are both set.
- R10: Writes to offsets 0x21 and 0x22 have no effect on the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Timer-clock enable; the count advances on edges where it is high |
| addr | input | 8 | Register byte address |
| wdata | input | 8 | Write data |
| wr | input | 1 | Write strobe, acts at the clock edge |
| rd | input | 1 | Read strobe; side effects occur at the clock edge |
| rdata | output | 8 | Read data, combinational from `addr` during a read |
| irq | output | 1 | Overflow interrupt request |

## Verification
Read data is combinational, so the value for a read is due within the same cycle as the `rd` strobe. The bench samples it two nanoseconds after the falling edge that drives the strobe. Buffer captures, flag arming and all write effects land on the next rising edge, so a dependent check is made only in a later read cycle. A count driven by N tick-high cycles is due one edge after the last of them, and the bench reads it after the following falling edge. The flag and `irq` follow the wrapping tick by the same single register stage. The tick-coincident clear is driven in one shared cycle, so both events meet at the same edge.

// File: rtl/modtimer_pkg.sv
package modtimer_pkg;

    localparam int BYTE_W = 8;
    localparam int CNT_W  = 2 * BYTE_W;

    // control/status bit positions
    localparam int FLAG_BIT = 7;
    localparam int IE_BIT   = 6;
    localparam int CLR_BIT  = 5;

    localparam logic [CNT_W-1:0] LIMIT_RESET = '1;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_CTRL,
        SEL_CNT_HI,
        SEL_CNT_LO,
        SEL_LIM_HI,
        SEL_LIM_LO
    } reg_sel_e;

    typedef struct packed {
        logic ovf;
        logic ie;
        logic armed;
    } flag_state_t;

    function automatic reg_sel_e decode_sel(input logic [BYTE_W-1:0] a,
                                            input logic [BYTE_W-1:0] base);
        logic [BYTE_W-1:0] off;
        off = a - base;
        case (off)
            8'd0:    return SEL_CTRL;
            8'd1:    return SEL_CNT_HI;
            8'd2:    return SEL_CNT_LO;
            8'd3:    return SEL_LIM_HI;
            8'd4:    return SEL_LIM_LO;
            default: return SEL_NONE;
        endcase
    endfunction

endpackage

// File: rtl/mt_counter.sv
module mt_counter
    import modtimer_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             clr,
    input  logic [CNT_W-1:0] limit,
    output logic [CNT_W-1:0] count,
    output logic             wrap
);
    logic [CNT_W-1:0] cnt_q;

    assign wrap  = tick && !clr && (cnt_q == limit);
    assign count = cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clr)
            cnt_q <= '0;
        else if (tick)
            cnt_q <= wrap ? '0 : cnt_q + 1'b1;
    end

    AST_CLR_ZERO:   assert property (@(posedge clk) disable iff (rst)
                        clr |=> (count == '0));                              // R7
    AST_WRAP_ZERO:  assert property (@(posedge clk) disable iff (rst)
                        (tick && !clr && count == limit) |=> (count == '0)); // R2
    AST_IDLE_HOLD:  assert property (@(posedge clk) disable iff (rst)
                        (!tick && !clr) |=> $stable(count));                 // R2
endmodule

// File: rtl/mt_rdlatch.sv
module mt_rdlatch
    import modtimer_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_hi,
    input  logic              rd_lo,
    input  logic [BYTE_W-1:0] live_lo,
    output logic [BYTE_W-1:0] lo_view
);
    logic              held_q;
    logic [BYTE_W-1:0] hold_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            held_q <= 1'b0;
            hold_q <= '0;
        end else if (rd_lo) begin
            held_q <= 1'b0;
        end else if (rd_hi && !held_q) begin
            held_q <= 1'b1;
            hold_q <= live_lo;
        end
    end

    assign lo_view = held_q ? hold_q : live_lo;

    AST_LATCH_HOLD:  assert property (@(posedge clk) disable iff (rst)
                         (held_q && !rd_lo) |=> (held_q && $stable(hold_q))); // R5
    AST_LO_RELEASE:  assert property (@(posedge clk) disable iff (rst)
                         rd_lo |=> !held_q);                                  // R5
    AST_HI_CAPTURE:  assert property (@(posedge clk) disable iff (rst)
                         (rd_hi && !rd_lo) |=> held_q);                       // R4
endmodule

// File: rtl/mt_limreg.sv
module mt_limreg
    import modtimer_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_hi,
    input  logic              wr_lo,
    input  logic [BYTE_W-1:0] wdata,
    output logic [CNT_W-1:0]  limit,
    output logic [BYTE_W-1:0] hi_view,
    output logic              pending
);
    logic [BYTE_W-1:0] stage_q;
    logic [CNT_W-1:0]  lim_q;
    logic              pend_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage_q <= LIMIT_RESET[CNT_W-1:BYTE_W];
            lim_q   <= LIMIT_RESET;
            pend_q  <= 1'b0;
        end else if (wr_hi) begin
            stage_q <= wdata;
            pend_q  <= 1'b1;
        end else if (wr_lo) begin
            lim_q   <= {stage_q, wdata};
            pend_q  <= 1'b0;
        end
    end

    assign limit   = lim_q;
    assign hi_view = stage_q;
    assign pending = pend_q;

    AST_PEND_SET:    assert property (@(posedge clk) disable iff (rst)
                         wr_hi |=> pending);                       // R6
    AST_LIM_STABLE:  assert property (@(posedge clk) disable iff (rst)
                         !wr_lo |=> $stable(limit));               // R6
endmodule

// File: rtl/modtimer.sv
module modtimer
    import modtimer_pkg::*;
#(
    parameter logic [BYTE_W-1:0] BASE_ADDR = 8'h20
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic [BYTE_W-1:0] addr,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              wr,
    input  logic              rd,
    output logic [BYTE_W-1:0] rdata,
    output logic              irq
);
    reg_sel_e          sel;
    logic [CNT_W-1:0]  count, limit;
    logic [BYTE_W-1:0] lo_view, lim_hi_view;
    logic              wrap, pending, set_ovf, clr_req, cnt_clr;
    logic              wr_ctrl, rd_ctrl;
    flag_state_t       fs_q;

    assign sel     = decode_sel(addr, BASE_ADDR);
    assign wr_ctrl = wr && (sel == SEL_CTRL);
    assign rd_ctrl = rd && (sel == SEL_CTRL);
    assign cnt_clr = wr_ctrl && wdata[CLR_BIT];

    mt_counter u_cnt (
        .clk(clk), .rst(rst), .tick(tick), .clr(cnt_clr),
        .limit(limit), .count(count), .wrap(wrap)
    );

    mt_rdlatch u_latch (
        .clk(clk), .rst(rst),
        .rd_hi(rd && (sel == SEL_CNT_HI)),
        .rd_lo(rd && (sel == SEL_CNT_LO)),
        .live_lo(count[BYTE_W-1:0]), .lo_view(lo_view)
    );

    mt_limreg u_lim (
        .clk(clk), .rst(rst),
        .wr_hi(wr && (sel == SEL_LIM_HI)),
        .wr_lo(wr && (sel == SEL_LIM_LO)),
        .wdata(wdata), .limit(limit), .hi_view(lim_hi_view), .pending(pending)
    );

    assign set_ovf = wrap && !pending;
    assign clr_req = wr_ctrl && fs_q.armed && !wdata[FLAG_BIT];

    always_ff @(posedge clk) begin
        if (rst) begin
            fs_q <= '0;
        end else begin
            if (set_ovf)      fs_q.ovf <= 1'b1;
            else if (clr_req) fs_q.ovf <= 1'b0;

            if (wr_ctrl)      fs_q.ie <= wdata[IE_BIT];

            if (wr_ctrl)                  fs_q.armed <= 1'b0;
            else if (rd_ctrl && fs_q.ovf) fs_q.armed <= 1'b1;
        end
    end

    assign irq = fs_q.ovf && fs_q.ie;

    always_comb begin
        rdata = '0;
        if (rd) begin
            case (sel)
                SEL_CTRL: begin
                    rdata[FLAG_BIT] = fs_q.ovf;
                    rdata[IE_BIT]   = fs_q.ie;
                end
                SEL_CNT_HI: rdata = count[CNT_W-1:BYTE_W];
                SEL_CNT_LO: rdata = lo_view;
                SEL_LIM_HI: rdata = lim_hi_view;
                SEL_LIM_LO: rdata = limit[BYTE_W-1:0];
                default:    rdata = '0;
            endcase
        end
    end

    AST_PEND_NOFLAG: assert property (@(posedge clk) disable iff (rst)
                         (pending && !fs_q.ovf) |=> !fs_q.ovf);          // R6
    AST_SET_WINS:    assert property (@(posedge clk) disable iff (rst)
                         set_ovf |=> fs_q.ovf);                          // R8
    AST_IRQ_RISE:    assert property (@(posedge clk) disable iff (rst)
                         $rose(irq) |-> fs_q.ie);                        // R9
    AST_CLRBIT_FLAG: assert property (@(posedge clk) disable iff (rst)
                         (cnt_clr && !clr_req && !set_ovf) |=> $stable(fs_q.ovf)); // R7
endmodule

// File: tb/sim_modtimer.sv
module sim_modtimer;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick = 1'b0;
    logic [7:0] addr = '0;
    logic [7:0] wdata = '0;
    logic       wr = 1'b0;
    logic       rd = 1'b0;
    logic [7:0] rdata;
    logic       irq;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    modtimer u0 (
        .clk(clk), .rst(rst), .tick(tick), .addr(addr), .wdata(wdata),
        .wr(wr), .rd(rd), .rdata(rdata), .irq(irq)
    );

    task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %02h expected %02h", tag, got, exp);
        end
    endtask

    task automatic reg_wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr = 1'b1;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic reg_rd(input logic [7:0] a, output logic [7:0] d);
        @(negedge clk);
        addr = a; rd = 1'b1;
        #2 d = rdata;
        @(negedge clk);
        rd = 1'b0;
    endtask

    task automatic expect_rd(input string tag, input logic [7:0] a, input logic [7:0] exp);
        logic [7:0] d;
        reg_rd(a, d);
        check(tag, d, exp);
    endtask

    task automatic run_ticks(input int n);
        @(negedge clk);
        tick = 1'b1;
        repeat (n) @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic t_reset;
        expect_rd("R1 status", 8'h20, 8'h00);
        expect_rd("R1 count hi", 8'h21, 8'h00);
        expect_rd("R1 count lo", 8'h22, 8'h00);
        expect_rd("R1 limit hi", 8'h23, 8'hFF);
        expect_rd("R1 limit lo", 8'h24, 8'hFF);
        check("R1 irq", {7'd0, irq}, 8'h00);
    endtask

    task automatic t_count;
        run_ticks(5);
        expect_rd("R2 count lo after 5 ticks", 8'h22, 8'h05);
        repeat (4) @(negedge clk);
        expect_rd("R2 held without tick", 8'h22, 8'h05);
    endtask

    task automatic t_latch;
        reg_wr(8'h20, 8'h20);
        expect_rd("R7 clear bit reads 0", 8'h20, 8'h00);
        run_ticks(254);
        expect_rd("R4 hi read", 8'h21, 8'h00);
        run_ticks(3);
        expect_rd("R5 second hi read live", 8'h21, 8'h01);
        expect_rd("R4 lo returns buffer", 8'h22, 8'hFE);
        expect_rd("R5 unlatched lo live", 8'h22, 8'h01);
    endtask

    task automatic t_wrap_flag;
        reg_wr(8'h20, 8'h20);
        reg_wr(8'h23, 8'h00);
        reg_wr(8'h24, 8'h05);
        run_ticks(5);
        expect_rd("R2 count at limit", 8'h22, 8'h05);
        expect_rd("R3 no flag before wrap", 8'h20, 8'h00);
        run_ticks(1);
        expect_rd("R2 wrapped to zero", 8'h22, 8'h00);
        expect_rd("R3 flag set on wrap", 8'h20, 8'h80);
        reg_wr(8'h20, 8'h00);
        expect_rd("R8 flag cleared", 8'h20, 8'h00);
    endtask

    task automatic t_irq;
        reg_wr(8'h20, 8'h40);
        check("R9 irq low without flag", {7'd0, irq}, 8'h00);
        run_ticks(6);
        check("R9 irq with flag and enable", {7'd0, irq}, 8'h01);
        expect_rd("R9 status", 8'h20, 8'hC0);
        reg_wr(8'h20, 8'h40);
        check("R9 irq drops with flag", {7'd0, irq}, 8'h00);
    endtask

    task automatic t_pending;
        reg_wr(8'h20, 8'h60);
        reg_wr(8'h23, 8'h00);
        run_ticks(6);
        expect_rd("R6 wrapped under pending", 8'h22, 8'h00);
        check("R6 irq blocked", {7'd0, irq}, 8'h00);
        expect_rd("R6 flag blocked", 8'h20, 8'h40);
        reg_wr(8'h24, 8'h03);
        run_ticks(4);
        expect_rd("R6 flag after commit", 8'h20, 8'hC0);
        expect_rd("R6 limit hi", 8'h23, 8'h00);
        expect_rd("R6 limit lo", 8'h24, 8'h03);
    endtask

    task automatic t_set_wins;
        run_ticks(3);
        expect_rd("R8 count at limit", 8'h22, 8'h03);
        @(negedge clk);
        addr = 8'h20; wdata = 8'h40; wr = 1'b1; tick = 1'b1;
        @(negedge clk);
        wr = 1'b0; tick = 1'b0;
        expect_rd("R8 set wins over clear", 8'h20, 8'hC0);
        expect_rd("R8 count wrapped", 8'h22, 8'h00);
        reg_wr(8'h20, 8'h40);
        expect_rd("R8 later clear", 8'h20, 8'h40);
    endtask

    task automatic t_clr_bit;
        run_ticks(4);
        run_ticks(2);
        reg_wr(8'h20, 8'h60);
        expect_rd("R7 flag kept, bit reads 0", 8'h20, 8'hC0);
        expect_rd("R7 count hi zero", 8'h21, 8'h00);
        expect_rd("R7 count lo zero", 8'h22, 8'h00);
    endtask

    task automatic t_ro_writes;
        reg_wr(8'h20, 8'h40);
        run_ticks(2);
        reg_wr(8'h21, 8'hAA);
        reg_wr(8'h22, 8'h55);
        expect_rd("R10 count hi unchanged", 8'h21, 8'h00);
        expect_rd("R10 count lo unchanged", 8'h22, 8'h02);
    endtask

    initial begin
        #4_000_000;
        checks++;
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_count();
        t_latch();
        t_wrap_flag();
        t_irq();
        t_pending();
        t_set_wins();
        t_clr_bit();
        t_ro_writes();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule